// File: doc/BRIEF.md
# SD Single-Line Data Status Monitor

This block watches the DAT0 line of an SD card interface running one data line wide. It follows one phase at a time, and each phase begins with a start request that carries the kind of transfer. On a read it waits for the start bit of the incoming block. It then runs the payload and the trailing 16 check bits through a CRC16 engine and tests the closing end bit. On a write it waits for the card's three-bit acknowledgement of the block it just received. It checks that acknowledgement and its closing bit, then times the busy period in which the card holds DAT0 low. A third kind of phase times only a busy period, as after a command whose response carries busy.

DAT0 is sampled only on cycles where the card clock enable is high. Each phase ends with exactly one verdict, given as single-cycle pulses: block good, CRC error, end bit error or data timeout. All three waiting windows are limited by programmable tick counts, and these counts are captured when the phase starts.

Top module: `sd_dat0_monitor`

## Requirements
- R1: After reset all four verdict outputs are low and the block stays idle until a start request with a kind of 00 (read), 01 (write) or 10 (busy only) is accepted. Kind 11 is not accepted.
- R2: A read accepts the first low DAT0 sample as the start bit. It then takes blk_len×8 data bits, followed by 16 check bits sent most significant bit first and one end bit. If the check bits match and the end bit is high, blk_good pulses in the cycle after the clock edge that samples the end bit. The check uses x^16+x^12+x^5+1 with the register starting at zero.
- R3: A read whose check bits do not match the CRC16 of its data raises crc_err and does not raise blk_good.
- R4: A read whose end bit is sampled low raises end_err. This is independent of crc_err, and both may pulse together.
- R5: A blk_len of 0 selects a block of 2048 bytes.
- R6: If a read sees no start bit within tmo_read sampled ticks, tmo_err pulses on the tick that reaches the limit and the phase ends. A limit of 0 acts as 1. tmo_err never coincides with crc_err or end_err.
- R7: On a write, the three acknowledgement bits after the acknowledgement start bit must be 0,1,0 in arrival order. Any other value raises crc_err and ends the phase without a busy period.
- R8: On a write, an acknowledgement end bit sampled low raises end_err and ends the phase.
- R9: If a write sees no acknowledgement start bit within tmo_token sampled ticks, tmo_err pulses.
- R10: After a correct acknowledgement, each low sample counts as busy. The first high sample pulses blk_good. If tmo_busy low samples are counted first, tmo_err pulses instead.
- R11: A busy-only phase applies the busy rule of R10 from its first sampled tick.
- R12: Cycles with clk_en low neither advance a phase nor produce a verdict, whatever DAT0 holds.
- R13: A start request made while a phase is running is ignored.
- R14: Each verdict pulse lasts one cycle, and blk_good never coincides with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only when idle |
| op | input | 2 | Phase kind: 00 read, 01 write, 10 busy only |
| blk_len | input | BLEN_W | Read block length in bytes, 0 means 2048 |
| tmo_read | input | TMO_W | Tick limit for a read start bit |
| tmo_token | input | TMO_W | Tick limit for the write acknowledgement |
| tmo_busy | input | TMO_W | Tick limit for a busy period |
| clk_en | input | 1 | Card clock enable, marks DAT0 sample cycles |
| dat0 | input | 1 | DAT0 line level |
| blk_good | output | 1 | Pulse: phase ended correctly |
| crc_err | output | 1 | Pulse: check bits or acknowledgement wrong |
| end_err | output | 1 | Pulse: end bit sampled low |
| tmo_err | output | 1 | Pulse: a waiting window expired |

## Verification
The bench drives DAT0 with the opposite of the intended bit on every disabled cycle. A design that sampled outside clk_en would then corrupt data and report CRC errors. Timeout limits of 0 and small values are applied, so an off-by-one counter shows up as a verdict one tick early or late against the per-cycle reference. A 2048-byte read exposes a length decode that treats 0 as empty. Zero-length busy periods, acknowledgements of 101 and 011, and an end bit of 0 paired with a bad CRC catch designs that skip busy, mis-order the acknowledgement bits, or let one error hide the other.

// File: rtl/sd_dat0_pkg.sv
package sd_dat0_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_BUSY  = 2'b10,
      OP_NONE  = 2'b11
   } sd_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_WAIT,
      ST_RD_BITS,
      ST_RD_END,
      ST_WR_WAIT,
      ST_WR_TOK,
      ST_WR_END,
      ST_BUSY
   } sd_state_e;

   localparam int          CRC_W      = 16;
   localparam logic [15:0] CRC_POLY   = 16'h1021;
   localparam int          TOK_W      = 3;
   localparam logic [2:0]  TOKEN_GOOD = 3'b010;

endpackage

// File: rtl/sd_crc_serial.sv
module sd_crc_serial #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h1021
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shift,
   input  logic din,
   output logic is_zero
);

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_d;
   logic         fb;

   initial begin
      if (W < 2) $error("sd_crc_serial: W must be at least 2");
      if (POLY[0] != 1'b1) $error("sd_crc_serial: POLY needs its constant term");
   end

   assign fb = crc_q[W-1] ^ din;

   generate
      for (genvar i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign crc_d[i] = POLY[i] & fb;
         end else begin : g_mid
            assign crc_d[i] = crc_q[i-1] ^ (POLY[i] & fb);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (clr) begin
         crc_q <= '0;
      end else if (shift) begin
         crc_q <= crc_d;
      end
   end

   assign is_zero = (crc_q == '0);

endmodule

// File: rtl/sd_phase_timer.sv
module sd_phase_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         miss,
   input  logic [W-1:0] limit,
   output logic         at_limit
);

   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_next;

   initial begin
      if (W < 2) $error("sd_phase_timer: W must be at least 2");
   end

   assign cnt_next = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
   // a miss that brings the count to the limit is the expiring one
   assign at_limit = (cnt_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (miss) begin
         cnt_q <= cnt_next[W-1:0];
      end
   end

endmodule

// File: rtl/sd_bit_window.sv
module sd_bit_window #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   logic [W-1:0] cnt_q;

   initial begin
      if (W < 3) $error("sd_bit_window: W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - {{(W-1){1'b0}}, 1'b1};
      end
   end

   assign last = (cnt_q == {{(W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sd_dat0_monitor.sv
module sd_dat0_monitor
   import sd_dat0_pkg::*;
#(
   parameter int BLEN_W = 11,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [BLEN_W-1:0] blk_len,
   input  logic [TMO_W-1:0]  tmo_read,
   input  logic [TMO_W-1:0]  tmo_token,
   input  logic [TMO_W-1:0]  tmo_busy,
   input  logic              clk_en,
   input  logic              dat0,
   output logic              blk_good,
   output logic              crc_err,
   output logic              end_err,
   output logic              tmo_err
);

   localparam int LEN_EFF_W = BLEN_W + 1;
   localparam int BIT_W     = BLEN_W + 5;

   initial begin
      if (BLEN_W < 1 || BLEN_W > 16) $error("sd_dat0_monitor: BLEN_W out of range");
      if (TMO_W < 2) $error("sd_dat0_monitor: TMO_W must be at least 2");
   end

   sd_state_e st_q, st_d;

   logic [BLEN_W-1:0]    len_q;
   logic [TMO_W-1:0]     lim_rd_q, lim_tok_q, lim_busy_q, lim_sel;
   logic [LEN_EFF_W-1:0] len_eff;
   logic [BIT_W-1:0]     rd_total;
   logic [TOK_W-1:0]     tok_q;

   logic tmr_clr, tmr_miss, tmr_at_limit;
   logic win_load, win_dec, win_last;
   logic [BIT_W-1:0] win_val;
   logic crc_clr, crc_shift, crc_zero;
   logic tok_shift, accept;
   logic good_d, crcerr_d, enderr_d, tmo_d;
   logic phase_active;

   assign phase_active = (st_q != ST_IDLE);
   assign accept       = (st_q == ST_IDLE) && start && (sd_op_e'(op) != OP_NONE);

   // zero length encodes the largest block
   assign len_eff  = (len_q == '0) ? {1'b1, {BLEN_W{1'b0}}} : {1'b0, len_q};
   assign rd_total = BIT_W'({len_eff, 3'b000}) + BIT_W'(CRC_W);

   always_comb begin
      case (st_q)
         ST_RD_WAIT: lim_sel = lim_rd_q;
         ST_WR_WAIT: lim_sel = lim_tok_q;
         default:    lim_sel = lim_busy_q;
      endcase
   end

   sd_phase_timer #(.W(TMO_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_clr),
      .miss     (tmr_miss),
      .limit    (lim_sel),
      .at_limit (tmr_at_limit)
   );

   sd_bit_window #(.W(BIT_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_load),
      .load_val (win_val),
      .dec      (win_dec),
      .last     (win_last)
   );

   sd_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (crc_clr),
      .shift   (crc_shift),
      .din     (dat0),
      .is_zero (crc_zero)
   );

   always_comb begin
      st_d      = st_q;
      tmr_clr   = 1'b0;
      tmr_miss  = 1'b0;
      win_load  = 1'b0;
      win_val   = '0;
      win_dec   = 1'b0;
      crc_clr   = 1'b0;
      crc_shift = 1'b0;
      tok_shift = 1'b0;
      good_d    = 1'b0;
      crcerr_d  = 1'b0;
      enderr_d  = 1'b0;
      tmo_d     = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_clr = 1'b1;
               crc_clr = 1'b1;
               case (sd_op_e'(op))
                  OP_READ:  st_d = ST_RD_WAIT;
                  OP_WRITE: st_d = ST_WR_WAIT;
                  default:  st_d = ST_BUSY;
               endcase
            end
         end
         ST_RD_WAIT: begin
            if (clk_en) begin
               if (!dat0) begin
                  win_load = 1'b1;
                  win_val  = rd_total;
                  crc_clr  = 1'b1;
                  st_d     = ST_RD_BITS;
               end else begin
                  tmr_miss = 1'b1;
                  if (tmr_at_limit) begin
                     tmo_d = 1'b1;
                     st_d  = ST_IDLE;
                  end
               end
            end
         end
         ST_RD_BITS: begin
            if (clk_en) begin
               crc_shift = 1'b1;
               win_dec   = 1'b1;
               if (win_last) st_d = ST_RD_END;
            end
         end
         ST_RD_END: begin
            if (clk_en) begin
               enderr_d = !dat0;
               crcerr_d = !crc_zero;
               good_d   = dat0 && crc_zero;
               st_d     = ST_IDLE;
            end
         end
         ST_WR_WAIT: begin
            if (clk_en) begin
               if (!dat0) begin
                  win_load = 1'b1;
                  win_val  = BIT_W'(TOK_W);
                  st_d     = ST_WR_TOK;
               end else begin
                  tmr_miss = 1'b1;
                  if (tmr_at_limit) begin
                     tmo_d = 1'b1;
                     st_d  = ST_IDLE;
                  end
               end
            end
         end
         ST_WR_TOK: begin
            if (clk_en) begin
               tok_shift = 1'b1;
               win_dec   = 1'b1;
               if (win_last) st_d = ST_WR_END;
            end
         end
         ST_WR_END: begin
            if (clk_en) begin
               crcerr_d = (tok_q != TOKEN_GOOD);
               enderr_d = !dat0;
               if ((tok_q == TOKEN_GOOD) && dat0) begin
                  tmr_clr = 1'b1;
                  st_d    = ST_BUSY;
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         ST_BUSY: begin
            if (clk_en) begin
               if (dat0) begin
                  good_d = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  tmr_miss = 1'b1;
                  if (tmr_at_limit) begin
                     tmo_d = 1'b1;
                     st_d  = ST_IDLE;
                  end
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         len_q      <= '0;
         lim_rd_q   <= '0;
         lim_tok_q  <= '0;
         lim_busy_q <= '0;
         tok_q      <= '0;
         blk_good   <= 1'b0;
         crc_err    <= 1'b0;
         end_err    <= 1'b0;
         tmo_err    <= 1'b0;
      end else begin
         st_q     <= st_d;
         blk_good <= good_d;
         crc_err  <= crcerr_d;
         end_err  <= enderr_d;
         tmo_err  <= tmo_d;
         if (accept) begin
            len_q      <= blk_len;
            lim_rd_q   <= tmo_read;
            lim_tok_q  <= tmo_token;
            lim_busy_q <= tmo_busy;
         end
         if (tok_shift) tok_q <= {tok_q[TOK_W-2:0], dat0};
      end
   end

endmodule

// File: rtl/sd_dat0_monitor_sva.sv
module sd_dat0_monitor_sva (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic clk_en,
   input logic phase_active,
   input logic blk_good,
   input logic crc_err,
   input logic end_err,
   input logic tmo_err
);

   logic any_verdict;
   assign any_verdict = blk_good | crc_err | end_err | tmo_err;

   assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase_active && !start) |=> !phase_active);

   assert_verdict_ends_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      any_verdict |-> (!phase_active && $past(phase_active)));

   assert_tmo_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |-> (!crc_err && !end_err && !blk_good));

   assert_no_tick_no_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_active && !clk_en) |=> !any_verdict);

   assert_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_active && start && !clk_en) |=> phase_active);

   assert_good_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
      blk_good |-> !(crc_err || end_err || tmo_err));

   assert_good_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
      blk_good |=> !blk_good);

   assert_error_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err || end_err || tmo_err) |=> !(crc_err || end_err || tmo_err));

endmodule

bind sd_dat0_monitor sd_dat0_monitor_sva u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .clk_en       (clk_en),
   .phase_active (phase_active),
   .blk_good     (blk_good),
   .crc_err      (crc_err),
   .end_err      (end_err),
   .tmo_err      (tmo_err)
);

// File: tb/sd_dat0_monitor_tb_top.sv
`timescale 1ns/1ps
module sd_dat0_monitor_tb_top;

   localparam int PH_IDLE = 0, PH_RW = 1, PH_RD = 2, PH_RE = 3,
                  PH_WW = 4, PH_WT = 5, PH_WE = 6, PH_BZ = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [10:0] blk_len = '0;
   logic [15:0] tmo_read = '0, tmo_token = '0, tmo_busy = '0;
   logic        clk_en = 1'b0;
   logic        dat0 = 1'b1;
   logic        blk_good, crc_err, end_err, tmo_err;

   always #2.5 clk = ~clk;

   sd_dat0_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk_len(blk_len),
      .tmo_read(tmo_read), .tmo_token(tmo_token), .tmo_busy(tmo_busy),
      .clk_en(clk_en), .dat0(dat0),
      .blk_good(blk_good), .crc_err(crc_err), .end_err(end_err), .tmo_err(tmo_err)
   );

   int    n_vec = 0, n_miss = 0, gap = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   int    seen_g = 0, seen_c = 0, seen_e = 0, seen_t = 0;

   // reference model state
   int   m_ph = PH_IDLE, m_nbits = 0, m_miss = 0, m_lrd = 0, m_ltok = 0, m_lbz = 0;
   bit   mq[$];
   logic e_good = 0, e_crc = 0, e_end = 0, e_tmo = 0;

   function automatic logic [15:0] crc16_of(input bit b[$], input int n);
      logic [15:0] c = 16'h0000;
      for (int k = 0; k < n; k++) begin
         logic fbk = c[15] ^ b[k];
         c = {c[14:0], 1'b0};
         if (fbk) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   function automatic int eff_lim(input int l);
      return (l == 0) ? 1 : l;
   endfunction

   always @(posedge clk) begin
      e_good = 0; e_crc = 0; e_end = 0; e_tmo = 0;
      if (!rst_n) begin
         m_ph = PH_IDLE;
      end else if (m_ph == PH_IDLE) begin
         if (start && op != 2'b11) begin
            m_nbits = ((blk_len == 0) ? 2048 : int'(blk_len)) * 8;
            m_lrd = int'(tmo_read); m_ltok = int'(tmo_token); m_lbz = int'(tmo_busy);
            m_miss = 0;
            m_ph = (op == 2'b00) ? PH_RW : (op == 2'b01) ? PH_WW : PH_BZ;
         end
      end else if (clk_en) begin
         case (m_ph)
            PH_RW, PH_WW: begin
               if (dat0 == 1'b0) begin
                  mq.delete();
                  m_ph = (m_ph == PH_RW) ? PH_RD : PH_WT;
               end else begin
                  m_miss++;
                  if (m_miss >= eff_lim(m_ph == PH_RW ? m_lrd : m_ltok)) begin
                     e_tmo = 1; m_ph = PH_IDLE;
                  end
               end
            end
            PH_RD: begin
               mq.push_back(dat0);
               if (mq.size() == m_nbits + 16) m_ph = PH_RE;
            end
            PH_RE: begin
               logic [15:0] rx = '0;
               for (int k = 0; k < 16; k++) rx = {rx[14:0], mq[m_nbits + k]};
               e_end  = !dat0;
               e_crc  = (crc16_of(mq, m_nbits) != rx);
               e_good = !e_end && !e_crc;
               m_ph   = PH_IDLE;
            end
            PH_WT: begin
               mq.push_back(dat0);
               if (mq.size() == 3) m_ph = PH_WE;
            end
            PH_WE: begin
               e_crc = !(mq[0] == 0 && mq[1] == 1 && mq[2] == 0);
               e_end = !dat0;
               if (!e_crc && !e_end) begin m_ph = PH_BZ; m_miss = 0; end
               else m_ph = PH_IDLE;
            end
            PH_BZ: begin
               if (dat0) begin e_good = 1; m_ph = PH_IDLE; end
               else begin
                  m_miss++;
                  if (m_miss >= eff_lim(m_lbz)) begin e_tmo = 1; m_ph = PH_IDLE; end
               end
            end
            default: m_ph = PH_IDLE;
         endcase
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if ({blk_good, crc_err, end_err, tmo_err} !== {e_good, e_crc, e_end, e_tmo}) begin
            n_miss++;
            $display("FAIL %s: good/crc/end/tmo actual %b expected %b at %0t", cur_req,
                     {blk_good, crc_err, end_err, tmo_err}, {e_good, e_crc, e_end, e_tmo}, $time);
         end
         seen_g += int'(blk_good); seen_c += int'(crc_err);
         seen_e += int'(end_err);  seen_t += int'(tmo_err);
      end
   end

   task automatic tick(input logic b);
      @(negedge clk); dat0 = b; clk_en = 1'b1;
      repeat (gap) begin @(negedge clk); clk_en = 1'b0; dat0 = ~b; end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); clk_en = 1'b0; dat0 = 1'b1; end
   endtask

   task automatic go(input logic [1:0] k, input int len, input int lrd, input int ltok, input int lbz);
      @(negedge clk);
      clk_en = 1'b0; start = 1'b1; op = k; blk_len = 11'(len);
      tmo_read = 16'(lrd); tmo_token = 16'(ltok); tmo_busy = 16'(lbz);
      @(negedge clk); start = 1'b0;
   endtask

   task automatic expect_seen(input int g, input int c, input int e, input int t, input string tag);
      idle(4);
      n_vec++;
      if (seen_g != g || seen_c != c || seen_e != e || seen_t != t) begin
         n_miss++;
         $display("FAIL %s: verdict counts g/c/e/t actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                  tag, seen_g, seen_c, seen_e, seen_t, g, c, e, t);
      end
      seen_g = 0; seen_c = 0; seen_e = 0; seen_t = 0;
   endtask

   task automatic rd_block(input int len, input int pre, input logic [15:0] flip,
                           input logic endbit, input bit poke);
      bit bits[$];
      logic [15:0] c;
      int n = ((len == 0) ? 2048 : len) * 8;
      go(2'b00, len, pre + 2, 0, 0);
      repeat (pre) tick(1'b1);
      tick(1'b0);
      for (int k = 0; k < n / 8; k++) begin
         logic [7:0] byt = 8'($urandom);
         for (int j = 7; j >= 0; j--) bits.push_back(byt[j]);
      end
      c = crc16_of(bits, n) ^ flip;
      for (int k = 0; k < n; k++) begin
         tick(bits[k]);
         if (poke && k == 5) begin
            @(negedge clk); clk_en = 1'b0; start = 1'b1; op = 2'b01;
            @(negedge clk); start = 1'b0;
         end
      end
      for (int j = 15; j >= 0; j--) tick(c[j]);
      tick(endbit);
   endtask

   task automatic wr_block(input int pre, input logic [2:0] tok, input logic endbit,
                           input int lows, input int lbz, input int ltok);
      go(2'b01, 1, 0, ltok, lbz);
      repeat (pre) tick(1'b1);
      tick(1'b0);
      tick(tok[2]); tick(tok[1]); tick(tok[0]);
      tick(endbit);
      repeat (lows) tick(1'b0);
      tick(1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      // R1: quiet after reset
      n_vec++;
      if ({blk_good, crc_err, end_err, tmo_err} !== 4'b0000) begin
         n_miss++;
         $display("FAIL R1: outputs after reset actual %b expected 0000", {blk_good, crc_err, end_err, tmo_err});
      end
      go(2'b11, 4, 1, 1, 1); tick(1'b1); tick(1'b1);
      expect_seen(0, 0, 0, 0, "R1");

      cur_req = "R2"; gap = 0; rd_block(4, 2, 16'h0000, 1'b1, 0); expect_seen(1, 0, 0, 0, "R2");
      cur_req = "R12"; gap = 2; rd_block(3, 1, 16'h0000, 1'b1, 0); expect_seen(1, 0, 0, 0, "R12");
      gap = 0;
      cur_req = "R3"; rd_block(2, 0, 16'h0040, 1'b1, 0); expect_seen(0, 1, 0, 0, "R3");
      cur_req = "R4"; rd_block(2, 0, 16'h0000, 1'b0, 0); expect_seen(0, 0, 1, 0, "R4");
      cur_req = "R4"; rd_block(1, 0, 16'h8000, 1'b0, 0); expect_seen(0, 1, 1, 0, "R4");
      cur_req = "R13"; gap = 1; rd_block(2, 0, 16'h0000, 1'b1, 1); expect_seen(1, 0, 0, 0, "R13");
      gap = 0;
      cur_req = "R5"; rd_block(0, 0, 16'h0000, 1'b1, 0); expect_seen(1, 0, 0, 0, "R5");

      cur_req = "R6"; go(2'b00, 4, 5, 0, 0); repeat (7) tick(1'b1); expect_seen(0, 0, 0, 1, "R6");
      cur_req = "R6"; go(2'b00, 4, 0, 0, 0); repeat (2) tick(1'b1); expect_seen(0, 0, 0, 1, "R6");

      cur_req = "R10"; wr_block(2, 3'b010, 1'b1, 4, 10, 8); expect_seen(1, 0, 0, 0, "R10");
      cur_req = "R10"; wr_block(0, 3'b010, 1'b1, 0, 2, 8); expect_seen(1, 0, 0, 0, "R10");
      cur_req = "R10"; wr_block(0, 3'b010, 1'b1, 8, 3, 8); expect_seen(0, 0, 0, 1, "R10");
      cur_req = "R7"; wr_block(0, 3'b101, 1'b1, 3, 10, 8); expect_seen(0, 1, 0, 0, "R7");
      cur_req = "R7"; wr_block(1, 3'b011, 1'b1, 3, 10, 8); expect_seen(0, 1, 0, 0, "R7");
      cur_req = "R8"; wr_block(0, 3'b010, 1'b0, 3, 10, 8); expect_seen(0, 0, 1, 0, "R8");
      cur_req = "R9"; go(2'b01, 1, 0, 6, 4); repeat (9) tick(1'b1); expect_seen(0, 0, 0, 1, "R9");

      cur_req = "R11"; gap = 1; go(2'b10, 1, 0, 0, 20); repeat (5) tick(1'b0); tick(1'b1);
      expect_seen(1, 0, 0, 0, "R11");
      gap = 0;
      cur_req = "R11"; go(2'b10, 1, 0, 0, 4); repeat (9) tick(1'b0); tick(1'b1);
      expect_seen(0, 0, 0, 1, "R11");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_miss++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

endmodule